// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Extension

This block is the combinational integer stage of a 32-bit load/store processor with three instruction formats. Each cycle the surrounding pipeline presents two register operands (the source operand and the target operand), a 16-bit immediate, a 5-bit shift amount and the raw 6-bit major opcode and 6-bit function field of the instruction. The block decodes those fields itself and returns a 32-bit result, a flag that requests an arithmetic-overflow trap, and a flag that marks an encoding it does not execute. It holds no state, so the result follows the inputs in the same cycle.

The operation set covers wrapping and trapping addition and subtraction, the bitwise operations, signed and unsigned set-on-less-than, the three shifts by a constant amount, and load-upper-immediate. For the immediate forms the second operand comes from the immediate field. The extension rule depends on the instruction: the logical immediates fill the upper half with zeros, while the arithmetic and compare immediates copy bit 15, and that includes the unsigned compare. Register file access, memory, branches, multiply and divide live elsewhere. The unit has no handshake, because it neither stores data nor stalls; the pipeline register around it does the flow control.

Top module: `alu_exec`

## Requirements
- R1: Function codes 0x20 and 0x21 (opcode 0x00) give src + tgt modulo 2^32. Opcodes 0x08 and 0x09 give src + sext(imm) modulo 2^32.
- R2: Function codes 0x22 and 0x23 (opcode 0x00) give src - tgt modulo 2^32.
- R3: `ovf` is 1 only for function 0x20, function 0x22 or opcode 0x08, and only when the exact signed result does not fit in 32 bits. It is 0 for 0x21, 0x23, 0x09 and every other operation.
- R4: Function 0x24 gives src & tgt, 0x25 gives src | tgt and 0x27 gives ~(src | tgt). Opcode 0x0C gives src & zext(imm) and opcode 0x0D gives src | zext(imm), where zext fills bits 31:16 with zeros.
- R5: Opcodes 0x08, 0x09, 0x0A and 0x0B use sext(imm), which is sixteen copies of imm[15] followed by imm.
- R6: Function 0x2A and opcode 0x0A return 1 when src is less than the second operand as two's-complement numbers, and 0 otherwise. Bits 31:1 of the result are always 0.
- R7: Function 0x2B and opcode 0x0B compare as unsigned numbers and return 1 or 0. Opcode 0x0B compares against sext(imm).
- R8: Function 0x00 gives tgt << shamt and 0x02 gives tgt >> shamt, both filling with zeros. Function 0x03 shifts tgt right by shamt and fills with copies of tgt[31]. The src operand plays no part in these.
- R9: Opcode 0x0F gives {imm, 16'h0000}.
- R10: Any other opcode, or any other function code under opcode 0x00, gives a result of 0, `ovf` = 0 and `illegal` = 1. `illegal` is 0 for every encoding listed in R1 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_val | input | 32 | Source register operand |
| tgt_val | input | 32 | Target register operand; also the shifted value |
| imm | input | 16 | Immediate field of the instruction |
| shamt | input | 5 | Shift amount field |
| opcode | input | 6 | Major opcode, bits 31:26 of the instruction |
| funct | input | 6 | Function field, decoded when opcode is 0x00 |
| result | output | 32 | Operation result |
| ovf | output | 1 | Overflow trap request from the trapping add and subtract |
| illegal | output | 1 | Encoding is not executed by this unit |

## Verification
The hardest case to reach from the ports is the overflow boundary. It shows up only when both signs line up and the sum or difference just crosses the most-positive or most-negative value, and uniform random operands seldom land there. The stimulus therefore aims directly at 0x7FFFFFFF + 1, 0x80000000 - 1, 0x80000000 - 0x80000000 and an addi with an immediate of 0x8000 at the low end. It runs the same operand pairs through the wrapping forms to show that they never flag. A random phase draws operands from a pool that mixes boundary words with random words, and its encodings include unlisted ones. This also covers sltiu with a negative immediate and shifts by 0 and 31.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_SLTIU = 6'h0B;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0F;

  localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
  localparam logic [FN_W-1:0] FN_SRA  = 6'h03;
  localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
  localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
  localparam logic [FN_W-1:0] FN_SUBU = 6'h23;
  localparam logic [FN_W-1:0] FN_AND  = 6'h24;
  localparam logic [FN_W-1:0] FN_OR   = 6'h25;
  localparam logic [FN_W-1:0] FN_NOR  = 6'h27;
  localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;
  localparam logic [FN_W-1:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    AOP_ADD, AOP_SUB, AOP_AND, AOP_OR, AOP_NOR, AOP_SLT, AOP_SLTU,
    AOP_SHL, AOP_SHR, AOP_SHRA, AOP_LUI, AOP_NONE
  } alu_op_e;

  typedef struct packed {
    alu_op_e op;
    logic    use_imm;
    logic    sign_ext;
    logic    trap;
    logic    bad;
  } alu_ctl_t;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output alu_ctl_t         ctl
);
  always_comb begin
    ctl = '{op: AOP_NONE, use_imm: 1'b0, sign_ext: 1'b0, trap: 1'b0, bad: 1'b0};
    unique case (opcode)
      OPC_REG: begin
        unique case (funct)
          FN_SLL:  ctl.op = AOP_SHL;
          FN_SRL:  ctl.op = AOP_SHR;
          FN_SRA:  ctl.op = AOP_SHRA;
          FN_ADD:  begin ctl.op = AOP_ADD; ctl.trap = 1'b1; end
          FN_ADDU: ctl.op = AOP_ADD;
          FN_SUB:  begin ctl.op = AOP_SUB; ctl.trap = 1'b1; end
          FN_SUBU: ctl.op = AOP_SUB;
          FN_AND:  ctl.op = AOP_AND;
          FN_OR:   ctl.op = AOP_OR;
          FN_NOR:  ctl.op = AOP_NOR;
          FN_SLT:  ctl.op = AOP_SLT;
          FN_SLTU: ctl.op = AOP_SLTU;
          default: ctl.bad = 1'b1;
        endcase
      end
      OPC_ADDI:  begin ctl.op = AOP_ADD;  ctl.use_imm = 1'b1; ctl.sign_ext = 1'b1; ctl.trap = 1'b1; end
      OPC_ADDIU: begin ctl.op = AOP_ADD;  ctl.use_imm = 1'b1; ctl.sign_ext = 1'b1; end
      OPC_SLTI:  begin ctl.op = AOP_SLT;  ctl.use_imm = 1'b1; ctl.sign_ext = 1'b1; end
      OPC_SLTIU: begin ctl.op = AOP_SLTU; ctl.use_imm = 1'b1; ctl.sign_ext = 1'b1; end
      OPC_ANDI:  begin ctl.op = AOP_AND;  ctl.use_imm = 1'b1; end
      OPC_ORI:   begin ctl.op = AOP_OR;   ctl.use_imm = 1'b1; end
      OPC_LUI:   ctl.op = AOP_LUI;
      default:   ctl.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [IMM_W-1:0] imm,
  input  logic             sign_ext,
  output logic [XLEN-1:0]  ext
);
  localparam int PAD_W = XLEN - IMM_W;
  logic fill;
  assign fill = sign_ext & imm[IMM_W-1];
  assign ext  = {{PAD_W{fill}}, imm};
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int XLEN = 32,
  parameter int SH_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] din,
  input  logic [SH_W-1:0] amt,
  input  logic            right,
  input  logic            arith,
  output logic [XLEN-1:0] dout
);
  always_comb begin
    if (!right)     dout = din << amt;
    else if (arith) dout = $unsigned($signed(din) >>> amt);
    else            dout = din >> amt;
  end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  localparam int SH_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]  src_val,
  input  logic [XLEN-1:0]  tgt_val,
  input  logic [IMM_W-1:0] imm,
  input  logic [SH_W-1:0]  shamt,
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output logic [XLEN-1:0]  result,
  output logic             ovf,
  output logic             illegal
);
  localparam int LO_W = XLEN - IMM_W;

  alu_ctl_t        ctl;
  logic [XLEN-1:0] imm_x, opnd_b, b_eff, sum, shout;
  logic            is_sub, sum_ovf, lt_s, lt_u;

  alu_decode u_dec (.opcode(opcode), .funct(funct), .ctl(ctl));

  alu_imm_ext #(.XLEN(XLEN), .IMM_W(IMM_W)) u_ext (
    .imm(imm), .sign_ext(ctl.sign_ext), .ext(imm_x)
  );

  alu_shifter #(.XLEN(XLEN), .SH_W(SH_W)) u_shf (
    .din(tgt_val), .amt(shamt),
    .right(ctl.op != AOP_SHL), .arith(ctl.op == AOP_SHRA),
    .dout(shout)
  );

  assign opnd_b  = ctl.use_imm ? imm_x : tgt_val;
  assign is_sub  = (ctl.op == AOP_SUB);
  assign b_eff   = is_sub ? ~opnd_b : opnd_b;
  assign sum     = src_val + b_eff + {{(XLEN-1){1'b0}}, is_sub};
  assign sum_ovf = (src_val[XLEN-1] == b_eff[XLEN-1]) && (sum[XLEN-1] != src_val[XLEN-1]);
  assign lt_s    = $signed(src_val) < $signed(opnd_b);
  assign lt_u    = src_val < opnd_b;

  always_comb begin
    unique case (ctl.op)
      AOP_ADD, AOP_SUB:          result = sum;
      AOP_AND:                   result = src_val & opnd_b;
      AOP_OR:                    result = src_val | opnd_b;
      AOP_NOR:                   result = ~(src_val | opnd_b);
      AOP_SLT:                   result = {{(XLEN-1){1'b0}}, lt_s};
      AOP_SLTU:                  result = {{(XLEN-1){1'b0}}, lt_u};
      AOP_SHL, AOP_SHR, AOP_SHRA: result = shout;
      AOP_LUI:                   result = {imm, {LO_W{1'b0}}};
      default:                   result = '0;
    endcase
  end

  assign ovf     = ctl.trap & sum_ovf;
  assign illegal = ctl.bad;
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk
  import alu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int SH_W  = 5
) (
  input logic [XLEN-1:0]  src_val,
  input logic [XLEN-1:0]  tgt_val,
  input logic [IMM_W-1:0] imm,
  input logic [SH_W-1:0]  shamt,
  input logic [OPC_W-1:0] opcode,
  input logic [FN_W-1:0]  funct,
  input logic [XLEN-1:0]  result,
  input logic             ovf,
  input logic             illegal
);
  localparam int LO_W = XLEN - IMM_W;
  logic reg_fmt, trap_enc, cmp_enc;

  assign reg_fmt  = (opcode == OPC_REG);
  assign trap_enc = (reg_fmt && (funct == FN_ADD || funct == FN_SUB)) || opcode == OPC_ADDI;
  assign cmp_enc  = (reg_fmt && (funct == FN_SLT || funct == FN_SLTU)) ||
                    opcode == OPC_SLTI || opcode == OPC_SLTIU;

  always_comb begin
    if (ovf === 1'b1)
      p_ovf_only_trapping_r3: assert (trap_enc) else $error("ovf on non-trapping encoding");
    if (illegal === 1'b1)
      p_illegal_quiet_r10: assert (result == '0 && !ovf) else $error("illegal op not quiet");
    if (cmp_enc === 1'b1)
      p_compare_bool_r6: assert (result[XLEN-1:1] == '0) else $error("compare not boolean");
    if (opcode === OPC_LUI)
      p_lui_shape_r9: assert (result == {imm, {LO_W{1'b0}}} && !illegal) else $error("lui shape");
    if (reg_fmt === 1'b1 && funct == FN_SLL && shamt == '0)
      p_shift_zero_r8: assert (result == tgt_val) else $error("shift by 0 changed value");
    if (opcode === OPC_ORI)
      p_ori_zext_r4: assert (result[XLEN-1:IMM_W] == src_val[XLEN-1:IMM_W]) else $error("ori touched upper half");
  end
endmodule

bind alu_exec alu_exec_chk #(.XLEN(XLEN), .IMM_W(IMM_W), .SH_W(SH_W)) u_chk (
  .src_val(src_val), .tgt_val(tgt_val), .imm(imm), .shamt(shamt),
  .opcode(opcode), .funct(funct), .result(result), .ovf(ovf), .illegal(illegal)
);

// File: tb/tb_alu_exec.sv
module tb_alu_exec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_val, tgt_val, result;
  logic [15:0] imm;
  logic [4:0]  shamt;
  logic [5:0]  opcode, funct;
  logic        ovf, illegal;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  alu_exec dut (
    .src_val(src_val), .tgt_val(tgt_val), .imm(imm), .shamt(shamt),
    .opcode(opcode), .funct(funct), .result(result), .ovf(ovf), .illegal(illegal)
  );

  function automatic string tag_of(input logic [5:0] opc, input logic [5:0] fn);
    if (opc == 6'h00) begin
      case (fn)
        6'h20, 6'h21: return "R1";
        6'h22, 6'h23: return "R2";
        6'h24, 6'h25, 6'h27: return "R4";
        6'h2A: return "R6";
        6'h2B: return "R7";
        6'h00, 6'h02, 6'h03: return "R8";
        default: return "R10";
      endcase
    end
    case (opc)
      6'h08, 6'h09: return "R1/R5";
      6'h0A: return "R6/R5";
      6'h0B: return "R7/R5";
      6'h0C, 6'h0D: return "R4";
      6'h0F: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
                       input logic [4:0] sh, input logic [5:0] opc, input logic [5:0] fn,
                       output logic [31:0] r, output logic o, output logic il);
    longint sa, sb, sx, wide;
    logic [31:0] sext, zext;
    sext = {{16{im[15]}}, im};
    zext = {16'h0000, im};
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    sx = longint'($signed(sext));
    r = 32'h0; o = 1'b0; il = 1'b0;
    if (opc == 6'h00) begin
      case (fn)
        6'h20: begin wide = sa + sb; r = a + b; o = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
        6'h21: r = a + b;
        6'h22: begin wide = sa - sb; r = a - b; o = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
        6'h23: r = a - b;
        6'h24: r = a & b;
        6'h25: r = a | b;
        6'h27: r = ~(a | b);
        6'h2A: r = (sa < sb) ? 32'd1 : 32'd0;
        6'h2B: r = (a < b) ? 32'd1 : 32'd0;
        6'h00: r = b << sh;
        6'h02: r = b >> sh;
        6'h03: begin
          r = b >> sh;
          for (int k = 0; k < 32; k++) if (k >= 32 - int'(sh)) r[k] = b[31];
        end
        default: il = 1'b1;
      endcase
    end else begin
      case (opc)
        6'h08: begin wide = sa + sx; r = a + sext; o = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
        6'h09: r = a + sext;
        6'h0A: r = (sa < sx) ? 32'd1 : 32'd0;
        6'h0B: r = (a < sext) ? 32'd1 : 32'd0;
        6'h0C: r = a & zext;
        6'h0D: r = a | zext;
        6'h0F: r = {im, 16'h0000};
        default: il = 1'b1;
      endcase
    end
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
                     input logic [4:0] sh, input logic [5:0] opc, input logic [5:0] fn);
    logic [31:0] er;
    logic eo, ei;
    string t;
    @(posedge clk);
    #2;
    src_val = a; tgt_val = b; imm = im; shamt = sh; opcode = opc; funct = fn;
    model(a, b, im, sh, opc, fn, er, eo, ei);
    t = tag_of(opc, fn);
    @(negedge clk);
    checks++;
    if (result !== er) begin
      errors++;
      $display("FAIL %s result opc=%h fn=%h a=%h b=%h imm=%h sh=%0d: actual %h expected %h",
               t, opc, fn, a, b, im, sh, result, er);
    end
    checks++;
    if (ovf !== eo) begin
      errors++;
      $display("FAIL R3 (%s) ovf opc=%h fn=%h a=%h b=%h imm=%h: actual %b expected %b",
               t, opc, fn, a, b, im, ovf, eo);
    end
    checks++;
    if (illegal !== ei) begin
      errors++;
      $display("FAIL R10 (%s) illegal opc=%h fn=%h: actual %b expected %b",
               t, opc, fn, illegal, ei);
    end
  endtask

  function automatic logic [31:0] pick_word();
    case ($urandom_range(0, 7))
      0: return 32'h7FFFFFFF;
      1: return 32'h80000000;
      2: return 32'hFFFFFFFF;
      3: return 32'h00000000;
      4: return 32'h00000001;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] opcs [8] = '{6'h00, 6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0F};
    logic [5:0] fns [12] = '{6'h00, 6'h02, 6'h03, 6'h20, 6'h21, 6'h22, 6'h23,
                             6'h24, 6'h25, 6'h27, 6'h2A, 6'h2B};
    src_val = '0; tgt_val = '0; imm = '0; shamt = '0; opcode = '0; funct = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-time state: all-zero encoding is a shift of zero (R8)
    run(32'h0, 32'h0, 16'h0, 5'd0, 6'h00, 6'h00);
    // R1 / R3 overflow boundaries
    run(32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, 6'h00, 6'h20);
    run(32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, 6'h00, 6'h21);
    run(32'h80000000, 32'hFFFFFFFF, 16'h0, 5'd0, 6'h00, 6'h20);
    run(32'h80000000, 32'h0, 16'h8000, 5'd0, 6'h08, 6'h3F);
    run(32'h80000000, 32'h0, 16'h8000, 5'd0, 6'h09, 6'h3F);
    run(32'h7FFFFFFE, 32'h0, 16'h0001, 5'd0, 6'h08, 6'h00);
    // R2 / R3
    run(32'h80000000, 32'h1, 16'h0, 5'd0, 6'h00, 6'h22);
    run(32'h80000000, 32'h1, 16'h0, 5'd0, 6'h00, 6'h23);
    run(32'h80000000, 32'h80000000, 16'h0, 5'd0, 6'h00, 6'h22);
    run(32'h0, 32'h80000000, 16'h0, 5'd0, 6'h00, 6'h22);
    // R4 / R5 extension rules
    run(32'hFFFFFFFF, 32'h0, 16'h8001, 5'd0, 6'h0C, 6'h00);
    run(32'h12340000, 32'h0, 16'hF00F, 5'd0, 6'h0D, 6'h00);
    run(32'h0F0F0F0F, 32'h00FF00FF, 16'h0, 5'd0, 6'h00, 6'h27);
    // R6 / R7
    run(32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, 6'h00, 6'h2A);
    run(32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, 6'h00, 6'h2B);
    run(32'h00000005, 32'h0, 16'hFFFF, 5'd0, 6'h0B, 6'h00);
    run(32'hFFFFFFFF, 32'h0, 16'hFFFF, 5'd0, 6'h0B, 6'h00);
    run(32'h00000005, 32'h0, 16'hFFFF, 5'd0, 6'h0A, 6'h00);
    // R8 shift extremes; src must not matter
    run(32'hDEADBEEF, 32'h80000001, 16'h0, 5'd31, 6'h00, 6'h03);
    run(32'hDEADBEEF, 32'h80000001, 16'h0, 5'd31, 6'h00, 6'h02);
    run(32'h12345678, 32'h80000001, 16'h0, 5'd31, 6'h00, 6'h00);
    // R9
    run(32'hFFFFFFFF, 32'hFFFFFFFF, 16'hA5C3, 5'd7, 6'h0F, 6'h2B);
    // R10 unlisted encodings
    run(32'h7FFFFFFF, 32'h1, 16'h7FFF, 5'd3, 6'h00, 6'h01);
    run(32'h7FFFFFFF, 32'h1, 16'h7FFF, 5'd3, 6'h0E, 6'h20);
    run(32'h7FFFFFFF, 32'h1, 16'h7FFF, 5'd3, 6'h23, 6'h20);
    // random phase over all encodings
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] o, f;
      o = ($urandom_range(0, 9) == 0) ? 6'($urandom()) : opcs[$urandom_range(0, 7)];
      f = ($urandom_range(0, 9) == 0) ? 6'($urandom()) : fns[$urandom_range(0, 11)];
      run(pick_word(), pick_word(), 16'($urandom()), 5'($urandom()), o, f);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule